// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column address of every beat of a synchronous DRAM burst, either inside a memory model or inside a controller that has to follow the memory's internal addressing. A start strobe captures the start column, the direction of the access and the programmed mode word. From the next cycle on, the block presents one column per cycle, a valid flag, and a flag on the final beat.

The mode word selects the burst length (1, 2, 4, 8 or the whole 256-column page), the ordering (wrap-around counting or XOR ordering), and an option that limits writes to a single beat while reads keep the programmed length. A page-length burst runs until a stop strobe ends it. A fresh start takes over at once, even during a burst that is still running. Length codes with no defined meaning give a single beat and raise an error flag.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is held and after it is released, valid_o and last_o are 0 until a start is accepted.
- R2: mode_i[2:0] sets the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. Beat 0 appears the cycle after start_i. last_o is 1 on the final beat only, and valid_o falls the cycle after it.
- R3: With mode_i[3]=0 (sequential), beat i keeps the column bits above log2(length) and sets the low log2(length) bits to (start + i) modulo the length.
- R4: With mode_i[3]=1 (interleaved), beat i of a fixed-length burst is the start column XOR i.
- R5: Code 111 selects a page burst. Beat i is (start + i) modulo 256 whatever mode_i[3] holds, last_o never rises, and the burst continues until stopped.
- R6: stop_i during an active burst makes valid_o 0 in the next cycle. stop_i while idle has no effect.
- R7: When mode_i[9]=1, a start with wr_i=1 gives a single beat. Starts with wr_i=0, and all starts when mode_i[9]=0, use the programmed length.
- R8: Codes 100, 101 and 110 give a single beat. err_o is 1 while mode_i[2:0] holds one of these codes and 0 otherwise.
- R9: The latency field mode_i[6:4] has no effect on the column sequence.
- R10: mode_i, wr_i and col_i are sampled only on start; changes to them during a burst do not alter it.
- R11: start_i during an active burst, including its last beat, puts beat 0 of the new burst out in the next cycle. start_i takes priority over stop_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | MODE_W (10) | Mode word: [2:0] length, [3] ordering, [6:4] latency, [9] single-beat writes |
| wr_i | input | 1 | Access is a write (sampled with start) |
| col_i | input | COL_W (8) | Start column |
| start_i | input | 1 | Begin a burst |
| stop_i | input | 1 | Terminate the active burst |
| col_o | output | COL_W (8) | Column of the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |
| err_o | output | 1 | Undefined length code on mode_i |

## Verification
Two events can fall in the same cycle: a new start can coincide with the last beat of a running burst, and it can also coincide with a stop strobe. The bench raises start_i exactly on the cycle where last_o is high, and separately raises start_i and stop_i together part-way through an 8-beat burst. In both cases the next cycle must show valid_o high with the new start column as beat 0, and the rest of the new burst must follow its own length and ordering. A dropped beat, a stale column or a burst that ends early counts as a failure.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

   // decoded burst configuration, captured at start
   typedef struct packed {
      logic       full;    // page-length burst
      logic [1:0] lg2;     // log2 of fixed length (0..3)
      logic       ileave;  // XOR ordering requested
      logic       bad;     // undefined length code
   } burst_cfg_t;

   localparam logic [2:0] LEN_CODE_1    = 3'b000;
   localparam logic [2:0] LEN_CODE_2    = 3'b001;
   localparam logic [2:0] LEN_CODE_4    = 3'b010;
   localparam logic [2:0] LEN_CODE_8    = 3'b011;
   localparam logic [2:0] LEN_CODE_PAGE = 3'b111;

endpackage

// File: rtl/sbs_mode_decode.sv
module sbs_mode_decode
   import sdr_burst_pkg::*;
#(
   parameter int MODE_W   = 10,
   parameter int TYPE_BIT = 3,
   parameter int WB_BIT   = 9
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic              wr_i,
   output burst_cfg_t        cfg_o
);

   logic [2:0] len_code;
   logic       single_wr;

   assign len_code  = mode_i[2:0];
   assign single_wr = wr_i & mode_i[WB_BIT];

   always_comb begin
      cfg_o        = '0;
      cfg_o.ileave = mode_i[TYPE_BIT];
      case (len_code)
         LEN_CODE_1:    cfg_o.lg2 = 2'd0;
         LEN_CODE_2:    cfg_o.lg2 = 2'd1;
         LEN_CODE_4:    cfg_o.lg2 = 2'd2;
         LEN_CODE_8:    cfg_o.lg2 = 2'd3;
         LEN_CODE_PAGE: cfg_o.full = 1'b1;
         default:       cfg_o.bad = 1'b1;
      endcase
      if (single_wr) begin
         cfg_o.full = 1'b0;
         cfg_o.lg2  = 2'd0;
      end
   end

   // latency and spare bits are carried in the word but not used here
   logic unused_mode;
   assign unused_mode = ^mode_i;

endmodule

// File: rtl/sbs_beat_ctrl.sv
module sbs_beat_ctrl
   import sdr_burst_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  burst_cfg_t       cfg_i,
   output logic             active_o,
   output logic [COL_W-1:0] cnt_o,
   output burst_cfg_t       cfg_q_o,
   output logic             last_o
);

   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   logic             active_q;
   logic [COL_W-1:0] cnt_q;
   burst_cfg_t       cfg_q;
   logic [COL_W-1:0] len_m1;
   logic             last_w;

   assign len_m1 = cfg_q.full ? '1 : ((ONE << cfg_q.lg2) - ONE);
   assign last_w = active_q & ~cfg_q.full & (cnt_q == len_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         cfg_q    <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         cfg_q    <= cfg_i;
      end else if (active_q) begin
         if (stop_i || last_w) begin
            active_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
      end
   end

   assign active_o = active_q;
   assign cnt_o    = cnt_q;
   assign cfg_q_o  = cfg_q;
   assign last_o   = last_w;

   // R2: a final-beat flag only ever marks a live beat
   a_r2_last_live: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> active_o);

   // R2: burst ends after its final beat unless restarted
   a_r2_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !active_o);

   // R6: stop ends an active burst
   a_r6_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && stop_i && !start_i) |=> !active_o);

   // R11: start always yields beat 0 next cycle
   a_r11_start_beat0: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (active_o && cnt_o == '0));

endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
   import sdr_burst_pkg::*;
#(
   parameter int COL_W     = 8,
   parameter bit EN_ILEAVE = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] cnt_i,
   input  burst_cfg_t       cfg_i,
   output logic [COL_W-1:0] col_o
);

   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   logic [COL_W-1:0] mask;
   logic [COL_W-1:0] seq_col;

   assign mask    = cfg_i.full ? '1 : ((ONE << cfg_i.lg2) - ONE);
   assign seq_col = (base_i & ~mask) | ((base_i + cnt_i) & mask);

   generate
      if (EN_ILEAVE) begin : g_ileave
         logic [COL_W-1:0] xor_col;
         assign xor_col = base_i ^ (cnt_i & mask);
         assign col_o   = (cfg_i.ileave && !cfg_i.full) ? xor_col : seq_col;
      end else begin : g_seq_only
         logic unused_ileave;
         assign unused_ileave = cfg_i.ileave;
         assign col_o = seq_col;
      end
   endgenerate

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
   import sdr_burst_pkg::*;
#(
   parameter int COL_W     = 8,
   parameter int MODE_W    = 10,
   parameter int TYPE_BIT  = 3,
   parameter int WB_BIT    = 9,
   parameter bit EN_ILEAVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              wr_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic              start_i,
   input  logic              stop_i,
   output logic [COL_W-1:0]  col_o,
   output logic              valid_o,
   output logic              last_o,
   output logic              err_o
);

   localparam int BLK_W = 3;  // low bits spanned by the longest fixed burst

   generate
      if (COL_W <= BLK_W) begin : g_chk_col
         $error("COL_W must exceed the 8-beat block width");
      end
      if (MODE_W < 7 || WB_BIT >= MODE_W || TYPE_BIT >= MODE_W) begin : g_chk_mode
         $error("mode word too narrow for its fields");
      end
   endgenerate

   burst_cfg_t       cfg_live;
   burst_cfg_t       cfg_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] cnt;
   logic             active;

   sbs_mode_decode #(
      .MODE_W   (MODE_W),
      .TYPE_BIT (TYPE_BIT),
      .WB_BIT   (WB_BIT)
   ) u_dec (
      .mode_i (mode_i),
      .wr_i   (wr_i),
      .cfg_o  (cfg_live)
   );

   sbs_beat_ctrl #(
      .COL_W (COL_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .stop_i   (stop_i),
      .cfg_i    (cfg_live),
      .active_o (active),
      .cnt_o    (cnt),
      .cfg_q_o  (cfg_q),
      .last_o   (last_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (start_i) begin
         base_q <= col_i;
      end
   end

   sbs_col_gen #(
      .COL_W     (COL_W),
      .EN_ILEAVE (EN_ILEAVE)
   ) u_col (
      .base_i (base_q),
      .cnt_i  (cnt),
      .cfg_i  (cfg_q),
      .col_o  (col_o)
   );

   assign valid_o = active;
   assign err_o   = cfg_live.bad;

   // R3: within a fixed burst the bits above the 8-beat block never move
   a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !cfg_q.full && $past(valid_o) && !$past(start_i))
         |-> $stable(col_o[COL_W-1:BLK_W]));

   // R8: a start under an undefined length code yields a one-beat burst
   a_r8_bad_single: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(start_i) && $past(err_o) && valid_o) |-> last_o);

endmodule

// File: tb/sdram_burst_seq_bench.sv
`timescale 1ns/1ps
module sdram_burst_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] mode_i = '0;
   logic       wr_i = 1'b0;
   logic [7:0] col_i = '0;
   logic       start_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [7:0] col_o;
   logic       valid_o;
   logic       last_o;
   logic       err_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sdram_burst_seq u_sdram_burst_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (mode_i),
      .wr_i    (wr_i),
      .col_i   (col_i),
      .start_i (start_i),
      .stop_i  (stop_i),
      .col_o   (col_o),
      .valid_o (valid_o),
      .last_o  (last_o),
      .err_o   (err_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_col(input int b, input int i, input int lg,
                                  input bit il, input bit full);
      int m;
      if (full) return (b + i) % 256;
      m = (1 << lg) - 1;
      if (il) return b ^ i;
      return (b & ~m) | ((b + i) & m);
   endfunction

   function automatic [9:0] mk_mode(input bit wb, input int cl, input bit il,
                                    input int code);
      return {wb, 2'b00, 3'(cl), il, 3'(code)};
   endfunction

   // start one burst and follow all of its beats, then check it has ended
   task automatic run_burst(input [9:0] mode, input bit wr, input [7:0] col,
                            input int nb, input int lg, input bit il,
                            input bit full, input bit scr, input string rc);
      @(negedge clk);
      mode_i = mode; wr_i = wr; col_i = col; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (scr) begin  // R10: disturb sampled inputs mid-burst
         mode_i = mode ^ 10'h3FF; wr_i = ~wr; col_i = ~col;
      end
      for (int i = 0; i < nb; i++) begin
         chk({rc, " col"}, int'(col_o), exp_col(int'(col), i, lg, il, full));
         chk("R2 valid", int'(valid_o), 1);
         chk("R2 last", int'(last_o), (i == nb - 1) ? 1 : 0);
         @(negedge clk);
      end
      chk("R2 end", int'(valid_o), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL R1 watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", int'(valid_o), 0);
      chk("R1 last in reset", int'(last_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", int'(valid_o), 0);
      chk("R1 last after reset", int'(last_o), 0);

      // R2 R3 R4 R9: sweep every start column, fixed length and ordering,
      // alternating the latency field between 2 and 3
      for (int lg = 0; lg < 4; lg++)
         for (int il = 0; il < 2; il++)
            for (int c = 0; c < 256; c++)
               run_burst(mk_mode(1'b0, (c % 2) ? 2 : 3, il[0], lg), 1'b0, 8'(c),
                         1 << lg, lg, il[0], 1'b0, 1'b0, il ? "R4/R9" : "R3/R9");

      // R5 R6: page burst wraps and runs until stopped; ordering bit ignored
      @(negedge clk);
      mode_i = mk_mode(1'b0, 2, 1'b1, 7); col_i = 8'd250; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 300; i++) begin
         chk("R5 page col", int'(col_o), (250 + i) % 256);
         chk("R5 no last", int'(last_o), 0);
         chk("R5 valid", int'(valid_o), 1);
         if (i == 299) stop_i = 1'b1;
         @(negedge clk);
      end
      stop_i = 1'b0;
      chk("R6 page stopped", int'(valid_o), 0);

      // R6: stop on a fixed burst after beat 2
      @(negedge clk);
      mode_i = mk_mode(1'b0, 3, 1'b0, 3); col_i = 8'h13; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk("R6 pre-stop col", int'(col_o), exp_col(8'h13, i, 3, 1'b0, 1'b0));
         if (i == 2) stop_i = 1'b1;
         @(negedge clk);
      end
      stop_i = 1'b0;
      chk("R6 fixed stopped", int'(valid_o), 0);

      // R6: stop while idle has no effect on the next burst
      stop_i = 1'b1;
      @(negedge clk);
      chk("R6 idle stop", int'(valid_o), 0);
      stop_i = 1'b0;
      run_burst(mk_mode(1'b0, 2, 1'b0, 2), 1'b0, 8'h2E, 4, 2, 1'b0, 1'b0, 1'b0, "R6");

      // R7: single-beat writes
      run_burst(mk_mode(1'b1, 2, 1'b0, 3), 1'b1, 8'h35, 1, 0, 1'b0, 1'b0, 1'b0, "R7 wr single");
      run_burst(mk_mode(1'b1, 2, 1'b0, 3), 1'b0, 8'h35, 8, 3, 1'b0, 1'b0, 1'b0, "R7 rd full len");
      run_burst(mk_mode(1'b0, 2, 1'b1, 3), 1'b1, 8'h35, 8, 3, 1'b1, 1'b0, 1'b0, "R7 wr full len");
      run_burst(mk_mode(1'b1, 2, 1'b0, 7), 1'b1, 8'hFE, 1, 0, 1'b0, 1'b0, 1'b0, "R7 page wr single");

      // R8: undefined length codes
      for (int code = 0; code < 8; code++) begin
         @(negedge clk);
         mode_i = mk_mode(1'b0, 3, 1'b0, code);
         #1;
         chk("R8 err flag", int'(err_o), (code >= 4 && code <= 6) ? 1 : 0);
         if (code >= 4 && code <= 6)
            run_burst(mk_mode(1'b0, 3, 1'b1, code), 1'b0, 8'h6B, 1, 0, 1'b1,
                      1'b0, 1'b0, "R8 single");
      end

      // R10: inputs changed during a burst are ignored
      run_burst(mk_mode(1'b1, 2, 1'b1, 3), 1'b0, 8'hA5, 8, 3, 1'b1, 1'b0, 1'b1, "R10 il");
      run_burst(mk_mode(1'b0, 3, 1'b0, 2), 1'b0, 8'h5E, 4, 2, 1'b0, 1'b0, 1'b1, "R10 seq");

      // R11: start on the last beat chains a new burst
      @(negedge clk);
      mode_i = mk_mode(1'b0, 2, 1'b0, 2); col_i = 8'h05; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk("R11 first col", int'(col_o), exp_col(8'h05, i, 2, 1'b0, 1'b0));
         if (i == 3) begin
            chk("R11 last seen", int'(last_o), 1);
            mode_i = mk_mode(1'b0, 2, 1'b1, 1); col_i = 8'h41; start_i = 1'b1;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      chk("R11 chained valid", int'(valid_o), 1);
      chk("R11 chained beat0", int'(col_o), 8'h41);
      chk("R11 chained last0", int'(last_o), 0);
      @(negedge clk);
      chk("R11 chained beat1", int'(col_o), 8'h40);
      chk("R11 chained last1", int'(last_o), 1);
      @(negedge clk);
      chk("R11 chained end", int'(valid_o), 0);

      // R11: start beats stop in the same cycle
      @(negedge clk);
      mode_i = mk_mode(1'b0, 2, 1'b0, 3); col_i = 8'h10; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      chk("R11 pre col", int'(col_o), 8'h11);
      mode_i = mk_mode(1'b0, 2, 1'b0, 1); col_i = 8'h81;
      start_i = 1'b1; stop_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
      chk("R11 start over stop valid", int'(valid_o), 1);
      chk("R11 start over stop col", int'(col_o), 8'h81);
      @(negedge clk);
      chk("R11 start over stop beat1", int'(col_o), 8'h80);
      chk("R11 start over stop last", int'(last_o), 1);
      @(negedge clk);
      chk("R11 start over stop end", int'(valid_o), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule